// File: doc/BRIEF.md
# Programmable Ratio Clock-Enable Divider

This block divides the system clock by a programmable ratio and marks the end of each period with an active-low pulse one clock wide. It is built from presettable binary counter stages of a fixed width, chained so that an upper stage advances only while every lower stage sits at all ones. The counter starts at a preset equal to two to the power of the total width minus the ratio, counts up to all ones, and on the following edge takes the preset again. The pulse that marks the all-ones state is the divided output. There is no separate comparator.

The ratio is presented directly, and the block derives the preset from it. A separate toggle output flips on every divide pulse. If the counter is programmed for N/2, this output is a square wave with a period of N clocks. After reset the chain holds at zero until a load strobe arrives. That strobe forces the first preset load, so the first output period is already one full ratio long. With a single stage the chain reloads on its own terminal count. With several stages the reload is gated on all stages reaching all ones together, while the count-enable path between stages stays separate.

Top module: `ratio_divider`

## Requirements
- R1: After reset `count_o` is zero, `div_n_o` is high and `half_o` is low. The count holds at zero until the first `load_i` strobe.
- R2: `load_i` high at a rising edge loads the preset (2^TOTAL_W − ratio) modulo 2^TOTAL_W into the count. This load has priority over counting and reload.
- R3: While running, the count rises by one per clock. A stage above the lowest advances only in a cycle where every lower stage holds all ones, so the carry crosses stage boundaries (0x00FE, 0x00FF, 0x0100).
- R4: `div_n_o` is low exactly while the whole running count is all ones, and it is never low for two clocks in a row.
- R5: The edge after the all-ones state reloads the preset. For any ratio from 2 to 2^TOTAL_W, the gap between successive pulses, and from the load strobe to the first pulse, is exactly the ratio in clocks. The ratio input value 0 encodes 2^TOTAL_W.
- R6: A one-stage build (NUM_STAGES = 1) divides by 2, 113 and 256. Ratio 113 uses preset 0x8F.
- R7: A two-stage build divides by ratios above 256, with the reload gated on both stages at all ones.
- R8: `half_o` is cleared by `load_i` and inverts on the edge following each divide pulse.
- R9: A change of `ratio_i` without a load strobe leaves the period in progress unchanged. It takes effect from the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start strobe; forces a preset load |
| ratio_i | input | STAGE_W*NUM_STAGES | Division ratio (0 means 2^TOTAL_W) |
| div_n_o | output | 1 | Active-low divide pulse, one clock wide |
| half_o | output | 1 | Toggle output, inverts after each pulse |
| count_o | output | STAGE_W*NUM_STAGES | Current chain count |

## Verification
The assertions assume that the ratio input never selects a ratio of one, so a freshly loaded preset is never all ones and the one-clock pulse width holds. The bench only applies ratios of two or more, with the top-width value written as zero. It changes the ratio either together with a load strobe or in the middle of a period, and never at the edge where the load is sampled. The load strobe is held high for one clock at a time, so the half-rate toggle is cleared only where it is intended.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

endpackage

// File: rtl/ratio_to_preset.sv
module ratio_to_preset #(
    parameter int TOTAL_W = 16
) (
    input  logic [TOTAL_W-1:0] ratio_i,
    output logic [TOTAL_W-1:0] preset_o
);

    // Preset is 2^TOTAL_W minus ratio, taken modulo 2^TOTAL_W.
    // A ratio field of zero therefore maps to preset zero (full range).
    always_comb begin
        preset_o = TOTAL_W'(0) - ratio_i;
    end

endmodule

// File: rtl/ctr_stage.sv
module ctr_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en_n,
    input  logic         load_n,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] cnt_o,
    output logic         full_n_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stg_t;

    stg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!load_n) begin
            st_d.cnt = preset_i;
        end else if (!cnt_en_n) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign full_n_o = ~(&st_q.cnt);

    // R2
    stage_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> cnt_o == $past(preset_i));

    // R3
    stage_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !cnt_en_n) |=> cnt_o == $past(cnt_o) + W'(1));

    // R3
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && cnt_en_n) |=> cnt_o == $past(cnt_o));

endmodule

// File: rtl/half_toggle.sv
module half_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic pulse_n_i,
    output logic half_o
);

    typedef struct packed {
        logic half;
    } tog_t;

    tog_t tg_d, tg_q;

    always_comb begin
        tg_d = tg_q;
        if (clear_i) begin
            tg_d.half = 1'b0;
        end else if (!pulse_n_i) begin
            tg_d.half = ~tg_q.half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tg_q <= '0;
        end else begin
            tg_q <= tg_d;
        end
    end

    assign half_o = tg_q.half;

endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
    parameter int STAGE_W    = 8,
    parameter int NUM_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [STAGE_W*NUM_STAGES-1:0] ratio_i,
    output logic                          div_n_o,
    output logic                          half_o,
    output logic [STAGE_W*NUM_STAGES-1:0] count_o
);

    import div_pkg::*;

    localparam int TOTAL_W = STAGE_W * NUM_STAGES;

    typedef struct packed {
        run_e mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TOTAL_W-1:0]    preset;
    logic [NUM_STAGES-1:0] full_n;
    logic [NUM_STAGES-1:0] en_n;
    logic                  chain_full;
    logic                  reload_n;

    ratio_to_preset #(.TOTAL_W(TOTAL_W)) u_preset (
        .ratio_i  (ratio_i),
        .preset_o (preset)
    );

    // Count-enable path: each stage waits for every lower stage at all ones.
    assign en_n[0] = (ctl_q.mode != ST_RUN);

    for (genvar i = 1; i < NUM_STAGES; i++) begin : g_carry
        assign en_n[i] = en_n[i-1] | full_n[i-1];
    end

    // Load path, kept apart from the carry path: all flags low together.
    assign chain_full = ~(|full_n);
    assign div_n_o    = ~((ctl_q.mode == ST_RUN) & chain_full);
    assign reload_n   = ~(load_i | ~div_n_o);

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        ctr_stage #(.W(STAGE_W)) u_stg (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_en_n (en_n[i]),
            .load_n   (reload_n),
            .preset_i (preset[i*STAGE_W +: STAGE_W]),
            .cnt_o    (count_o[i*STAGE_W +: STAGE_W]),
            .full_n_o (full_n[i])
        );
    end

    half_toggle u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (load_i),
        .pulse_n_i (div_n_o),
        .half_o    (half_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (load_i) begin
            ctl_d.mode = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: ST_IDLE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == ST_IDLE) |-> count_o == '0);

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_n_o |=> div_n_o);

    // R5
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_n_o |=> count_o == $past(preset));

    // R8
    half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_n_o && !load_i) |=> half_o != $past(half_o));

endmodule

// File: tb/sim_ratio_divider.sv
`timescale 1ns/1ps
module sim_ratio_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load0 = 1'b0;
    logic        load1 = 1'b0;
    logic [15:0] ratio0 = 16'd0;
    logic [7:0]  ratio1 = 8'd0;
    logic        div0, div1, half0, half1;
    logic [15:0] cnt0;
    logic [7:0]  cnt1;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int last0 = 0;
    int last1 = 0;
    int q0[$];
    int q1[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    ratio_divider #(.STAGE_W(8), .NUM_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load0), .ratio_i(ratio0),
        .div_n_o(div0), .half_o(half0), .count_o(cnt0)
    );

    ratio_divider #(.STAGE_W(8), .NUM_STAGES(1)) u1 (
        .clk(clk), .rst_n(rst_n), .load_i(load1), .ratio_i(ratio1),
        .div_n_o(div1), .half_o(half1), .count_o(cnt1)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Scoreboard monitors: measure pulse spacing, compare with queued ratios.
    always @(negedge clk) begin
        if (rst_n) begin
            if (load0) last0 = cyc;
            else if (!div0) begin
                if (q0.size() > 0) begin
                    int e;
                    e = q0.pop_front();
                    check((cyc - last0) == e, "R5/R7 u0 period", cyc - last0, e);
                end
                last0 = cyc;
            end
            if (load1) last1 = cyc;
            else if (!div1) begin
                if (q1.size() > 0) begin
                    int e;
                    e = q1.pop_front();
                    check((cyc - last1) == e, "R5/R6 u1 period", cyc - last1, e);
                end
                last1 = cyc;
            end
        end
    end

    task automatic start0(input int r, input int n);
        q0.delete();
        for (int i = 0; i < n; i++) q0.push_back(r);
        ratio0 = 16'(r);
        load0 = 1'b1;
        tick();
        load0 = 1'b0;
    endtask

    task automatic start1(input int r, input int n);
        q1.delete();
        for (int i = 0; i < n; i++) q1.push_back(r);
        ratio1 = 8'(r);
        load1 = 1'b1;
        tick();
        load1 = 1'b0;
    endtask

    task automatic drain0();
        int g = 0;
        while (q0.size() != 0 && g < 20000) begin tick(); g++; end
        check(q0.size() == 0, "R5 u0 all pulses seen", q0.size(), 0);
    endtask

    task automatic drain1();
        int g = 0;
        while (q1.size() != 0 && g < 20000) begin tick(); g++; end
        check(q1.size() == 0, "R5 u1 all pulses seen", q1.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (5) tick();
        // R1: reset state and idle hold before any load
        check(cnt0 == 16'd0, "R1 u0 count idle", cnt0, 0);
        check(cnt1 == 8'd0, "R1 u1 count idle", cnt1, 0);
        check(div0 == 1'b1, "R1 u0 div_n idle", div0, 1);
        check(half0 == 1'b0, "R1 u0 half idle", half0, 0);

        // R2: load takes preset 65536-300 = 0xFED4
        start0(300, 0);
        check(cnt0 == 16'hFED4, "R2 u0 preset", cnt0, 16'hFED4);
        repeat (10) tick();
        check(cnt0 == 16'hFEDE, "R3 u0 increment", cnt0, 16'hFEDE);

        // R3: carry across the stage boundary, preset 0x00FE
        start0(16'hFF02, 0);
        check(cnt0 == 16'h00FE, "R3 carry start", cnt0, 16'h00FE);
        tick();
        check(cnt0 == 16'h00FF, "R3 carry low full", cnt0, 16'h00FF);
        tick();
        check(cnt0 == 16'h0100, "R3 carry into upper", cnt0, 16'h0100);

        // R6: single stage ratios 2, 113 (preset 0x8F), 256 (field 0)
        start1(2, 4);   drain1();
        start1(113, 4);
        check(cnt1 == 8'h8F, "R6 preset for 113", cnt1, 8'h8F);
        drain1();
        start1(256, 3); drain1();

        // R7: two-stage ratios including values above 256
        start0(2, 4);    drain0();
        start0(113, 3);  drain0();
        start0(256, 3);  drain0();
        start0(300, 3);  drain0();
        start0(1000, 3); drain0();

        // R8: toggle output with ratio 4 on the single stage
        start1(4, 0);
        check(half1 == 1'b0, "R8 half cleared by load", half1, 0);
        repeat (4) tick();
        check(half1 == 1'b1, "R8 half after first pulse", half1, 1);
        repeat (4) tick();
        check(half1 == 1'b0, "R8 half after second pulse", half1, 0);

        // R9: ratio change mid-period applies from the next reload
        start1(10, 2);
        q1.push_back(20);
        q1.push_back(20);
        begin
            int g = 0;
            while (q1.size() > 3 && g < 1000) begin tick(); g++; end
        end
        repeat (2) tick();
        ratio1 = 8'd20;
        drain1();

        // R4: pulse never lasts two clocks (ratio 2 on u0)
        start0(2, 0);
        begin
            int lows = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!div0) lows++;
            end
            check(lows == 5, "R4 one-clock pulses at ratio 2", lows, 5);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule